// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Queue

This block holds a short, ordered list of DMA segment descriptors that a host loads through a small register-write port. A descriptor is a memory address paired with a command word. The command word carries the transfer direction, an endian-swap flag, a per-entry flag that stops the completion interrupt, and the segment length. The host first writes the address, which is only held in a staging register. It then writes the command word. That second write commits the staged address and the command as one entry.

A DMA engine drains the queue through a valid/ready pop port, in the order the entries were pushed. When the engine finishes a segment it pulses a done input. The block raises its completion interrupt only if the segment that was last handed out did not have its interrupt-suppress flag set. A single configuration bit empties the queue and parks it disabled. Writing that bit as zero enables the queue. A push is dropped, and a sticky error flag is set, when the queue is full or the staged address is not 8-byte aligned.

Top module: `sgq_desc_queue`

## Requirements
- R1: After a synchronous active-low reset the count is 0, the queue is disabled, the error flag is 0, `pop_valid` is 0 and `done_irq` is 0.
- R2: A write with `wr_sel`=0 (address select) loads `wr_data[47:0]` into the staging register only. The count does not change.
- R3: When the queue is enabled, a write with `wr_sel`=1 (command select) commits the staged address together with the command word as one entry. `q_count` shows the increase on the cycle after the write.
- R4: Entries leave in push order. `pop_valid` is high exactly when the queue is enabled and the count is non-zero. Each cycle with `pop_valid` and `pop_ready` both high removes the head entry and lowers the count by one.
- R5: The queue holds at most DEPTH (default 16) entries. A command write while full is dropped, the count stays at DEPTH, and the error flag is set. The full test uses the count before any pop in the same cycle.
- R6: A command write while the staged address has any of bits [2:0] set is dropped and sets the error flag.
- R7: A write with `wr_sel`=2 (configuration) and `wr_data[16]`=1 empties the queue, disables it and clears the error flag. While disabled, `pop_valid` stays low and command writes are ignored without raising an error. `wr_sel`=3 has no effect.
- R8: A configuration write with `wr_data[16]`=0 enables the queue without disturbing its contents.
- R9: `done_irq` is high for one cycle, on the cycle after `seg_done`, only if the entry most recently popped had its interrupt-suppress bit clear. Before any pop, `seg_done` raises nothing.
- R10: The command word fields are laid out as follows: size (segment length in 64-bit words minus one, 20 bits so up to 8 MB) in `wr_data[19:0]`, direction in bit 24, endian swap in bit 25, interrupt suppress in bit 26. These fields appear unchanged on the `pop_*` outputs of the head entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 command, 2 configuration |
| wr_data | input | 64 | Register write data |
| q_count | output | 5 | Number of stored entries |
| q_enabled | output | 1 | Queue enabled |
| q_error | output | 1 | Sticky push-fault flag |
| pop_valid | output | 1 | Head entry available to the engine |
| pop_ready | input | 1 | Engine takes the head entry |
| pop_addr | output | 48 | Head entry address |
| pop_dir | output | 1 | Head entry direction |
| pop_swap | output | 1 | Head entry endian swap |
| pop_nointr | output | 1 | Head entry interrupt suppress |
| pop_size | output | 20 | Head entry length in words minus one |
| seg_done | input | 1 | Engine finished the current segment |
| done_irq | output | 1 | Completion interrupt pulse |

## Verification
The hardest situation to reach is a full queue that receives a command write in the same cycle as the engine pops. In that case the push must still be refused, because fullness is judged on the count before the pop. The random phase therefore drives long runs of pushes against a slow, randomly stalling `pop_ready`, so the queue often sits at DEPTH while pops and command writes overlap. Misaligned pushes and flushes are mixed in as well. A behavioural queue model in the bench tracks every cycle, so each of these overlaps is compared as it happens.

// File: rtl/sgq_pkg.sv
// Shared constants and descriptor type for the descriptor queue.
// Assumes a 64-bit host write bus; field positions are fixed here.
package sgq_pkg;
    localparam int WORD_W     = 64;
    localparam int ADDR_W     = 48;
    localparam int SIZE_W     = 20;
    localparam int DIR_BIT    = 24;
    localparam int SWAP_BIT   = 25;
    localparam int NOINT_BIT  = 26;
    localparam int CLR_BIT    = 16;
    localparam int ALIGN_BITS = 3;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              dir;
        logic              swap;
        logic              nointr;
        logic [SIZE_W-1:0] size;
    } desc_t;
endpackage

// File: rtl/sgq_host_port.sv
// Host register decode: stages the address, builds the descriptor on a
// command write, and keeps the enable and sticky error state.
// Assumes one register write per cycle; ring_full is the pre-pop state.
module sgq_host_port
    import sgq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ring_full,
    output desc_t             push_desc,
    output logic              push_go,
    output logic              flush,
    output logic              enabled,
    output logic              error
);
    logic [ADDR_W-1:0] staged_addr;
    logic              is_cmd;
    logic              is_cfg;
    logic              cmd_fault;

    // Decode the write and decide whether a command write is accepted.
    always_comb begin
        is_cmd    = wr_en && (wr_sel == SEL_CMD);
        is_cfg    = wr_en && (wr_sel == SEL_CFG);
        flush     = is_cfg && wr_data[CLR_BIT];
        cmd_fault = is_cmd && enabled &&
                    (ring_full || (staged_addr[ALIGN_BITS-1:0] != '0));
        push_go   = is_cmd && enabled && !cmd_fault;
    end

    // Pair the staged address with the fields of the command word.
    always_comb begin
        push_desc.addr   = staged_addr;
        push_desc.dir    = wr_data[DIR_BIT];
        push_desc.swap   = wr_data[SWAP_BIT];
        push_desc.nointr = wr_data[NOINT_BIT];
        push_desc.size   = wr_data[SIZE_W-1:0];
    end

    // Address staging register, written only by the address select.
    always_ff @(posedge clk) begin
        if (!rst_n)
            staged_addr <= '0;
        else if (wr_en && (wr_sel == SEL_ADDR))
            staged_addr <= wr_data[ADDR_W-1:0];
    end

    // Enable state: the clear bit disables, a zero clear bit enables.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enabled <= 1'b0;
        else if (is_cfg)
            enabled <= !wr_data[CLR_BIT];
    end

    // Sticky fault flag, cleared only by a flush.
    always_ff @(posedge clk) begin
        if (!rst_n)
            error <= 1'b0;
        else if (flush)
            error <= 1'b0;
        else if (cmd_fault)
            error <= 1'b1;
    end

    AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && enabled && staged_addr[ALIGN_BITS-1:0] != '0) |=> error); // R6
    AST_DISABLED_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> !push_go); // R7
    AST_FLUSH_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!error && !enabled)); // R7
endmodule

// File: rtl/sgq_ring.sv
// Circular descriptor store with occupancy count.
// Assumes push is never requested when full and pop never when empty;
// flush wins over push and pop in the same cycle.
module sgq_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [W-1:0]     rd_data,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Head entry and full flag seen by the rest of the block.
    always_comb begin
        rd_data = mem[rd_ptr];
        full    = (count == CNT_W'(DEPTH));
    end

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= push_data;
    end

    // Pointer and count bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0)); // R4
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0)); // R7
endmodule

// File: rtl/sgq_done_irq.sv
// Completion interrupt: remembers the suppress flag of the entry last
// handed to the engine and pulses the interrupt when that segment ends.
// Assumes seg_done refers to the entry popped before the current cycle.
module sgq_done_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic pop_fire,
    input  logic pop_nointr,
    input  logic seg_done,
    output logic done_irq
);
    logic held_nointr;

    // Track the suppress flag of the in-flight segment; none is in flight at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_nointr <= 1'b1;
        else if (pop_fire)
            held_nointr <= pop_nointr;
    end

    // One-cycle interrupt pulse for an unsuppressed completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_irq <= 1'b0;
        else
            done_irq <= seg_done && !held_nointr;
    end

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $past(seg_done)); // R9
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq && !seg_done) |=> !done_irq); // R9
endmodule

// File: rtl/sgq_desc_queue.sv
// Scatter-gather descriptor queue top: host register port, ring store,
// engine pop port and completion interrupt.
// Assumes the engine samples pop_* when pop_valid and pop_ready are high.
module sgq_desc_queue
    import sgq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [CNT_W-1:0]  q_count,
    output logic              q_enabled,
    output logic              q_error,
    output logic              pop_valid,
    input  logic              pop_ready,
    output logic [ADDR_W-1:0] pop_addr,
    output logic              pop_dir,
    output logic              pop_swap,
    output logic              pop_nointr,
    output logic [SIZE_W-1:0] pop_size,
    input  logic              seg_done,
    output logic              done_irq
);
    localparam int DESC_W = $bits(desc_t);

    desc_t             push_desc;
    desc_t             head;
    logic [DESC_W-1:0] head_bits;
    logic              push_go;
    logic              flush;
    logic              ring_full;
    logic              pop_fire;

    sgq_host_port u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ring_full (ring_full),
        .push_desc (push_desc),
        .push_go   (push_go),
        .flush     (flush),
        .enabled   (q_enabled),
        .error     (q_error)
    );

    sgq_ring #(.DEPTH(DEPTH), .W(DESC_W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_go),
        .push_data (push_desc),
        .pop       (pop_fire),
        .flush     (flush),
        .rd_data   (head_bits),
        .count     (q_count),
        .full      (ring_full)
    );

    // Engine-side view of the head entry and the pop handshake.
    always_comb begin
        head       = desc_t'(head_bits);
        pop_valid  = q_enabled && (q_count != '0);
        pop_fire   = pop_valid && pop_ready;
        pop_addr   = head.addr;
        pop_dir    = head.dir;
        pop_swap   = head.swap;
        pop_nointr = head.nointr;
        pop_size   = head.size;
    end

    sgq_done_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop_fire   (pop_fire),
        .pop_nointr (head.nointr),
        .seg_done   (seg_done),
        .done_irq   (done_irq)
    );

    AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> q_enabled); // R7
    AST_ADDR_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ADDR && !pop_fire) |=> $stable(q_count)); // R2
endmodule

// File: tb/sgq_desc_queue_tb_top.sv
// Bench: behavioural queue model updated every clock and compared with the
// design at each falling edge, plus directed checks per requirement.
module sgq_desc_queue_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [63:0] wr_data;
    logic [4:0]  q_count;
    logic        q_enabled, q_error, pop_valid, pop_ready;
    logic [47:0] pop_addr;
    logic        pop_dir, pop_swap, pop_nointr;
    logic [19:0] pop_size;
    logic        seg_done, done_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_on = 1'b0;

    // Reference model state.
    logic [63:0] q_addr[$];
    logic [63:0] q_cmd[$];
    logic        m_en, m_err, m_irq, m_held;
    logic [63:0] m_staged;

    always #2 clk = ~clk;

    sgq_desc_queue #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .q_count(q_count), .q_enabled(q_enabled),
        .q_error(q_error), .pop_valid(pop_valid), .pop_ready(pop_ready),
        .pop_addr(pop_addr), .pop_dir(pop_dir), .pop_swap(pop_swap),
        .pop_nointr(pop_nointr), .pop_size(pop_size), .seg_done(seg_done),
        .done_irq(done_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Model update at every rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin
        int  sz;
        bit  popped;
        if (!rst_n) begin
            q_addr.delete(); q_cmd.delete();
            m_en = 0; m_err = 0; m_irq = 0; m_held = 1; m_staged = '0;
        end else begin
            sz     = q_addr.size();
            popped = pop_ready && m_en && (sz > 0);
            m_irq  = seg_done && !m_held;
            if (popped) begin
                m_held = q_cmd[0][26];
                void'(q_addr.pop_front());
                void'(q_cmd.pop_front());
            end
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_staged = wr_data & 64'h0000_FFFF_FFFF_FFFF;
                    2'd1: if (m_en) begin
                        if (sz == DEPTH || m_staged[2:0] != 3'd0) m_err = 1;
                        else begin q_addr.push_back(m_staged); q_cmd.push_back(wr_data); end
                    end
                    2'd2: if (wr_data[16]) begin
                        q_addr.delete(); q_cmd.delete(); m_en = 0; m_err = 0;
                    end else m_en = 1;
                    default: ;
                endcase
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk("R3", "count", 64'(q_count), 64'(q_addr.size()));
            chk("R8", "enabled", 64'(q_enabled), 64'(m_en));
            chk("R6", "error", 64'(q_error), 64'(m_err));
            chk("R9", "irq", 64'(done_irq), 64'(m_irq));
            chk("R4", "pop_valid", 64'(pop_valid), 64'(m_en && q_addr.size() > 0));
            if (m_en && q_addr.size() > 0) begin
                chk("R4", "pop_addr", 64'(pop_addr), q_addr[0]);
                chk("R10", "pop_size", 64'(pop_size), 64'(q_cmd[0][19:0]));
                chk("R10", "pop_dir", 64'(pop_dir), 64'(q_cmd[0][24]));
                chk("R10", "pop_swap", 64'(pop_swap), 64'(q_cmd[0][25]));
                chk("R10", "pop_nointr", 64'(pop_nointr), 64'(q_cmd[0][26]));
            end
        end
    end

    function automatic logic [63:0] mk_cmd(input int size, input bit dir,
                                           input bit swap, input bit noint);
        logic [63:0] c = '0;
        c[19:0] = 20'(size);
        c[24] = dir; c[25] = swap; c[26] = noint;
        return c;
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [63:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input logic [63:0] a, input logic [63:0] c);
        wr(2'd0, a);
        wr(2'd1, c);
    endtask

    task automatic pop_one();
        pop_ready = 1'b1;
        @(negedge clk);
        pop_ready = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
        pop_ready = 1'b0; seg_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "count", 64'(q_count), 0);
        chk("R1", "enabled", 64'(q_enabled), 0);
        chk("R1", "error", 64'(q_error), 0);
        chk("R1", "pop_valid", 64'(pop_valid), 0);
        chk("R1", "irq", 64'(done_irq), 0);

        // R7 command writes while disabled are ignored
        push(64'h1000, mk_cmd(7, 0, 0, 0));
        chk("R7", "count while disabled", 64'(q_count), 0);
        chk("R7", "no error while disabled", 64'(q_error), 0);
        wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7", "select 3 no effect", 64'(q_enabled), 0);

        // R8 enable
        wr(2'd2, 64'h0);
        chk("R8", "enabled", 64'(q_enabled), 1);

        // R2 address write alone
        wr(2'd0, 64'h2000);
        chk("R2", "count after address", 64'(q_count), 0);

        // R3 / R10 pushes
        wr(2'd1, mk_cmd(20'hFFFFF, 1, 0, 1));
        chk("R3", "count after first push", 64'(q_count), 1);
        push(64'hABCD_0000_0008, mk_cmd(3, 0, 1, 0));
        push(64'h0000_0000_0040, mk_cmd(0, 1, 1, 1));
        chk("R3", "count after three", 64'(q_count), 3);
        chk("R10", "head size", 64'(pop_size), 64'hFFFFF);
        chk("R10", "head dir", 64'(pop_dir), 1);

        // R4 in-order pop
        pop_one();
        chk("R4", "count after pop", 64'(q_count), 2);
        chk("R4", "next head addr", 64'(pop_addr), 64'hABCD_0000_0008);
        chk("R10", "next swap", 64'(pop_swap), 1);

        // R9 unsuppressed head popped then done
        pop_one();
        seg_done = 1'b1; @(negedge clk); seg_done = 1'b0;
        chk("R9", "irq for unsuppressed", 64'(done_irq), 1);
        @(negedge clk);
        chk("R9", "irq one cycle", 64'(done_irq), 0);
        pop_one();
        seg_done = 1'b1; @(negedge clk); seg_done = 1'b0;
        chk("R9", "irq suppressed", 64'(done_irq), 0);

        // R5 fill and overflow
        for (int i = 0; i < DEPTH; i++) push(64'(i * 8), mk_cmd(i, i[0], i[1], 1));
        chk("R5", "count full", 64'(q_count), DEPTH);
        wr(2'd1, mk_cmd(1, 0, 0, 0));
        chk("R5", "count after overflow", 64'(q_count), DEPTH);
        chk("R5", "error after overflow", 64'(q_error), 1);
        // R5 full push with simultaneous pop is still dropped
        pop_ready = 1'b1; wr(2'd1, mk_cmd(2, 0, 0, 0)); pop_ready = 1'b0;
        chk("R5", "full push with pop", 64'(q_count), DEPTH - 1);

        // R7 flush
        wr(2'd2, 64'h1_0000);
        chk("R7", "count after flush", 64'(q_count), 0);
        chk("R7", "disabled after flush", 64'(q_enabled), 0);
        chk("R7", "error cleared", 64'(q_error), 0);

        // R6 misaligned push
        wr(2'd2, 64'h0);
        push(64'h1004, mk_cmd(5, 0, 0, 0));
        chk("R6", "misaligned count", 64'(q_count), 0);
        chk("R6", "misaligned error", 64'(q_error), 1);
        wr(2'd2, 64'h1_0000);
        wr(2'd2, 64'h0);

        // Random phase against the model.
        for (int cyc = 0; cyc < 4000; cyc++) begin
            int r;
            r = $urandom_range(0, 99);
            pop_ready = ($urandom_range(0, 3) == 0);
            seg_done  = ($urandom_range(0, 4) == 0);
            wr_en = 1'b0;
            if (r < 30) begin
                wr_en = 1'b1; wr_sel = 2'd0;
                wr_data = {$urandom, $urandom};
                if ($urandom_range(0, 7) != 0) wr_data[2:0] = 3'd0;
            end else if (r < 75) begin
                wr_en = 1'b1; wr_sel = 2'd1; wr_data = {$urandom, $urandom};
            end else if (r < 77) begin
                wr_en = 1'b1; wr_sel = 2'd2; wr_data = 64'h1_0000;
            end else if (r < 85) begin
                wr_en = 1'b1; wr_sel = 2'd2; wr_data = 64'h0;
            end else if (r < 87) begin
                wr_en = 1'b1; wr_sel = 2'd3; wr_data = {$urandom, $urandom};
            end
            @(negedge clk);
        end
        wr_en = 1'b0; pop_ready = 1'b0; seg_done = 1'b0;
        @(negedge clk);
        summary();
        $finish;
    end
endmodule